// File: doc/BRIEF.md
# TLB Autorefill Page Walker

This block services a single translation miss at a time. When the lookup logic reports that a virtual address found no matching TLB entry, the walker works out where the page-table entry for that address lives in virtual space. It builds that address from a page-table base value and the faulting address. It asks the TLB to translate it as a privileged data load, fetches one 32-bit entry from memory, and installs the entry into one of four refill ways chosen in rotation.

A walk either completes with a written TLB entry or gives up. When it gives up, the requester gets back the miss cause it would have raised anyway. The walk is abandoned when the page-table address itself does not translate, or when the memory read returns an error. The walker never starts a second walk to resolve its own page-table address. On success it also records the faulting address in an exception-address register that other logic can read.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `miss_ready` is 1, `resp_valid`, `wr_en`, `xl_valid` and `rd_valid` are 0, and `excvaddr` is 0.
- R2: While `xl_valid` is high, `xl_vaddr` equals (`pt_base` OR (`miss_vaddr` >> 10)) with bits [1:0] forced to 0. It uses the miss address accepted for the current walk.
- R3: If `xl_ok` is 0 in the translate cycle, the walk ends with `resp_fail`=1, no memory read is issued and no TLB entry is written.
- R4: The memory read is addressed at the `xl_paddr` returned in the translate cycle. `rd_valid` and `rd_addr` hold steady until `rd_ready` is seen.
- R5: A response with `rsp_err`=1 ends the walk with `resp_fail`=1 and no TLB write.
- R6: On success, exactly one `wr_en` pulse carries the fetched entry in `wr_pte`, its bits [5:4] in `wr_ring`, the faulting address in `wr_vaddr` and the miss kind in `wr_is_data`. The next cycle shows `resp_valid`=1 with `resp_fail`=0.
- R7: The refill way is a 2-bit counter that resets to 0 and is incremented before use, so successive successful refills go to ways 1, 2, 3, 0, 1, and so on. Failed walks do not advance it.
- R8: `excvaddr` takes the faulting address on each successful refill and is unchanged by failed walks.
- R9: `resp_cause` is 0 on success. On failure it is 16 for an instruction miss (`miss_is_data`=0) and 24 for a data miss (`miss_is_data`=1).
- R10: Only one miss is in flight. `miss_ready` is 0 from acceptance until the cycle after `resp_valid`, and a miss offered in that time is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pt_base | input | 32 | Page-table base, virtual |
| miss_valid | input | 1 | Miss request present |
| miss_ready | output | 1 | Walker idle, miss accepted when both high |
| miss_vaddr | input | 32 | Faulting virtual address |
| miss_is_data | input | 1 | 1 = data access miss, 0 = instruction fetch miss |
| xl_valid | output | 1 | Translate request for page-table address |
| xl_vaddr | output | 32 | Page-table entry virtual address |
| xl_ok | input | 1 | Same-cycle translation success (ring 0 data load) |
| xl_paddr | input | 32 | Same-cycle translated physical address |
| rd_valid | output | 1 | Memory read request |
| rd_ready | input | 1 | Memory accepts the read |
| rd_addr | output | 32 | Physical read address |
| rsp_valid | input | 1 | Read data returned, no earlier than the cycle after acceptance |
| rsp_data | input | 32 | Fetched page-table entry |
| rsp_err | input | 1 | Read failed |
| wr_en | output | 1 | TLB write strobe |
| wr_way | output | 2 | Refill way |
| wr_is_data | output | 1 | Target TLB: 1 data, 0 instruction |
| wr_vaddr | output | 32 | Faulting virtual address for the new entry |
| wr_pte | output | 32 | Fetched entry |
| wr_ring | output | 2 | Ring of the new entry |
| excvaddr | output | 32 | Exception virtual-address register |
| resp_valid | output | 1 | Walk finished (one cycle) |
| resp_fail | output | 1 | Walk failed |
| resp_cause | output | 6 | Miss cause on failure, else 0 |

## Verification
Two events can fall in one cycle: the end of one walk (`resp_valid`) and a new miss offered on `miss_valid`. The bench holds `miss_valid` high with a poison address for the whole of a walk, including its response cycle. It then drops the request and checks that exactly one translate request was issued, carrying the first address. The sweep covers successes, translation faults and read errors. These run with varying read stalls and both miss kinds. Page-table addresses, entries, ways and causes are predicted arithmetically.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_XLATE = 3'd1,
    S_READ  = 3'd2,
    S_WRITE = 3'd3,
    S_DONE  = 3'd4
  } ptw_state_e;

  localparam int unsigned CAUSE_W = 6;
  localparam logic [CAUSE_W-1:0] CAUSE_IMISS = 6'd16;
  localparam logic [CAUSE_W-1:0] CAUSE_DMISS = 6'd24;
  localparam logic [CAUSE_W-1:0] CAUSE_NONE  = 6'd0;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int unsigned VA_W      = 32,
  parameter int unsigned PTE_SHIFT = 10,
  parameter int unsigned ALIGN_B   = 2
) (
  input  logic [VA_W-1:0] base,
  input  logic [VA_W-1:0] fault_va,
  output logic [VA_W-1:0] pte_va
);
  localparam logic [VA_W-1:0] ALIGN_MASK = ~((VA_W'(1) << ALIGN_B) - VA_W'(1));

  logic [VA_W-1:0] shifted;

  always_comb begin
    shifted = fault_va >> PTE_SHIFT;
    pte_va  = (base | shifted) & ALIGN_MASK;
  end
endmodule

// File: rtl/ptw_way_ctr.sv
module ptw_way_ctr #(
  parameter int unsigned WAYS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    adv,
  output logic [$clog2(WAYS)-1:0] next_way
);
  localparam int unsigned WAY_W = $clog2(WAYS);

  logic [WAY_W-1:0] cnt_q;
  logic [WAY_W-1:0] cnt_d;

  always_comb begin
    next_way = cnt_q + WAY_W'(1);
    cnt_d    = cnt_q;
    if (adv) cnt_d = next_way;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (adv) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
  import ptw_pkg::*;
#(
  parameter int unsigned VA_W     = 32,
  parameter int unsigned PA_W     = 32,
  parameter int unsigned PTE_W    = 32,
  parameter int unsigned RING_LSB = 4,
  parameter int unsigned RING_W   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                miss_valid,
  output logic                miss_ready,
  input  logic [VA_W-1:0]     miss_vaddr,
  input  logic                miss_is_data,
  output logic [VA_W-1:0]     walk_va,
  output logic                xl_valid,
  input  logic                xl_ok,
  input  logic [PA_W-1:0]     xl_paddr,
  output logic                rd_valid,
  input  logic                rd_ready,
  output logic [PA_W-1:0]     rd_addr,
  input  logic                rsp_valid,
  input  logic [PTE_W-1:0]    rsp_data,
  input  logic                rsp_err,
  output logic                wr_en,
  output logic                wr_is_data,
  output logic [PTE_W-1:0]    wr_pte,
  output logic [RING_W-1:0]   wr_ring,
  output logic [VA_W-1:0]     excvaddr,
  output logic                resp_valid,
  output logic                resp_fail,
  output logic [CAUSE_W-1:0]  resp_cause
);
  ptw_state_e       state_q, state_d;
  logic [VA_W-1:0]  va_q;
  logic             dat_q;
  logic [PA_W-1:0]  pa_q;
  logic [PTE_W-1:0] pte_q;
  logic             issued_q, issued_d;
  logic             fail_q, fail_d;
  logic [VA_W-1:0]  exc_q;

  logic accept, xl_take, rsp_take, pa_en, pte_en, exc_en, issue_en;

  always_comb begin
    accept   = (state_q == S_IDLE) && miss_valid;
    xl_take  = (state_q == S_XLATE);
    rsp_take = (state_q == S_READ) && issued_q && rsp_valid;
    pa_en    = xl_take && xl_ok;
    pte_en   = rsp_take && !rsp_err;
    exc_en   = (state_q == S_WRITE);
    issue_en = (state_q == S_READ) && !issued_q && rd_ready;
  end

  always_comb begin
    state_d  = state_q;
    fail_d   = fail_q;
    issued_d = issued_q;
    unique case (state_q)
      S_IDLE: begin
        if (accept) begin
          state_d = S_XLATE;
          fail_d  = 1'b0;
        end
      end
      S_XLATE: begin
        issued_d = 1'b0;
        if (xl_ok) begin
          state_d = S_READ;
        end else begin
          state_d = S_DONE;
          fail_d  = 1'b1;
        end
      end
      S_READ: begin
        if (issue_en) issued_d = 1'b1;
        if (rsp_take) begin
          if (rsp_err) begin
            state_d = S_DONE;
            fail_d  = 1'b1;
          end else begin
            state_d = S_WRITE;
          end
        end
      end
      S_WRITE: state_d = S_DONE;
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      fail_q   <= 1'b0;
      issued_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      fail_q   <= fail_d;
      issued_q <= issued_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q  <= '0;
      dat_q <= 1'b0;
    end else if (accept) begin
      va_q  <= miss_vaddr;
      dat_q <= miss_is_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pa_q <= '0;
    else if (pa_en) pa_q <= xl_paddr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pte_q <= '0;
    else if (pte_en) pte_q <= rsp_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) exc_q <= '0;
    else if (exc_en) exc_q <= va_q;
  end

  always_comb begin
    miss_ready = (state_q == S_IDLE);
    walk_va    = va_q;
    xl_valid   = (state_q == S_XLATE);
    rd_valid   = (state_q == S_READ) && !issued_q;
    rd_addr    = pa_q;
    wr_en      = (state_q == S_WRITE);
    wr_is_data = dat_q;
    wr_pte     = pte_q;
    wr_ring    = pte_q[RING_LSB +: RING_W];
    excvaddr   = exc_q;
    resp_valid = (state_q == S_DONE);
    resp_fail  = fail_q;
    resp_cause = fail_q ? (dat_q ? CAUSE_DMISS : CAUSE_IMISS) : CAUSE_NONE;
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int unsigned VA_W      = 32,
  parameter int unsigned PA_W      = 32,
  parameter int unsigned PTE_W     = 32,
  parameter int unsigned PTE_SHIFT = 10,
  parameter int unsigned WAYS      = 4,
  parameter int unsigned RING_LSB  = 4,
  parameter int unsigned SYNC_LEN  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [VA_W-1:0]          pt_base,
  input  logic                     miss_valid,
  output logic                     miss_ready,
  input  logic [VA_W-1:0]          miss_vaddr,
  input  logic                     miss_is_data,
  output logic                     xl_valid,
  output logic [VA_W-1:0]          xl_vaddr,
  input  logic                     xl_ok,
  input  logic [PA_W-1:0]          xl_paddr,
  output logic                     rd_valid,
  input  logic                     rd_ready,
  output logic [PA_W-1:0]          rd_addr,
  input  logic                     rsp_valid,
  input  logic [PTE_W-1:0]         rsp_data,
  input  logic                     rsp_err,
  output logic                     wr_en,
  output logic [$clog2(WAYS)-1:0]  wr_way,
  output logic                     wr_is_data,
  output logic [VA_W-1:0]          wr_vaddr,
  output logic [PTE_W-1:0]         wr_pte,
  output logic [1:0]               wr_ring,
  output logic [VA_W-1:0]          excvaddr,
  output logic                     resp_valid,
  output logic                     resp_fail,
  output logic [CAUSE_W-1:0]       resp_cause
);
  localparam int unsigned RING_W = 2;

  logic [SYNC_LEN-1:0] rst_sync_q;
  logic                core_rst_n;
  logic [VA_W-1:0]     walk_va;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_LEN-2:0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[SYNC_LEN-1];

  ptw_addr_gen #(
    .VA_W(VA_W), .PTE_SHIFT(PTE_SHIFT), .ALIGN_B(2)
  ) u_addr (
    .base(pt_base), .fault_va(walk_va), .pte_va(xl_vaddr)
  );

  ptw_way_ctr #(.WAYS(WAYS)) u_way (
    .clk(clk), .rst_n(core_rst_n), .adv(wr_en), .next_way(wr_way)
  );

  ptw_fsm #(
    .VA_W(VA_W), .PA_W(PA_W), .PTE_W(PTE_W),
    .RING_LSB(RING_LSB), .RING_W(RING_W)
  ) u_fsm (
    .clk(clk), .rst_n(core_rst_n),
    .miss_valid(miss_valid), .miss_ready(miss_ready),
    .miss_vaddr(miss_vaddr), .miss_is_data(miss_is_data),
    .walk_va(walk_va),
    .xl_valid(xl_valid), .xl_ok(xl_ok), .xl_paddr(xl_paddr),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .wr_en(wr_en), .wr_is_data(wr_is_data), .wr_pte(wr_pte),
    .wr_ring(wr_ring), .excvaddr(excvaddr),
    .resp_valid(resp_valid), .resp_fail(resp_fail), .resp_cause(resp_cause)
  );

  assign wr_vaddr = walk_va;
endmodule

// File: rtl/ptw_walker_checker.sv
module ptw_walker_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        miss_ready,
  input logic        xl_valid,
  input logic        rd_valid,
  input logic        rd_ready,
  input logic [31:0] rd_addr,
  input logic        wr_en,
  input logic [1:0]  wr_way,
  input logic [31:0] excvaddr,
  input logic        resp_valid,
  input logic        resp_fail
);
  logic [1:0] last_way_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_way_q <= 2'd0;
    else if (wr_en) last_way_q <= wr_way;
  end

  p_read_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

  p_write_ok_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> resp_valid && !resp_fail);

  p_way_rotate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_way == last_way_q + 2'd1);

  p_fail_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_fail |-> !wr_en);

  p_exc_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(excvaddr));

  p_busy_no_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_valid || rd_valid || wr_en || resp_valid) |-> !miss_ready);
endmodule

bind ptw_walker ptw_walker_checker u_chk (
  .clk(clk), .rst_n(rst_n), .miss_ready(miss_ready),
  .xl_valid(xl_valid), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_addr(rd_addr), .wr_en(wr_en), .wr_way(wr_way),
  .excvaddr(excvaddr), .resp_valid(resp_valid), .resp_fail(resp_fail)
);

// File: tb/ptw_walker_bench.sv
module ptw_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pt_base = '0;
  logic        miss_valid = 1'b0;
  logic        miss_ready;
  logic [31:0] miss_vaddr = '0;
  logic        miss_is_data = 1'b0;
  logic        xl_valid;
  logic [31:0] xl_vaddr;
  logic        xl_ok;
  logic [31:0] xl_paddr;
  logic        rd_valid;
  logic        rd_ready;
  logic [31:0] rd_addr;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_data = '0;
  logic        rsp_err = 1'b0;
  logic        wr_en;
  logic [1:0]  wr_way;
  logic        wr_is_data;
  logic [31:0] wr_vaddr;
  logic [31:0] wr_pte;
  logic [1:0]  wr_ring;
  logic [31:0] excvaddr;
  logic        resp_valid;
  logic        resp_fail;
  logic [5:0]  resp_cause;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  logic       xl_fail_mode = 1'b0;
  logic       rd_err_mode = 1'b0;
  int         stall_len = 0;
  int         stall_cnt = 0;

  localparam logic [31:0] XL_KEY = 32'h4000_0000;

  always #10 clk = ~clk;

  ptw_walker u_ptw_walker (.*);

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h5A3C_96E1 ^ (a << 3);
  endfunction

  assign xl_ok    = !xl_fail_mode;
  assign xl_paddr = xl_vaddr ^ XL_KEY;
  assign rd_ready = (stall_cnt >= stall_len);

  always @(posedge clk) begin
    if (rd_valid && !rd_ready) stall_cnt <= stall_cnt + 1;
    else if (!rd_valid) stall_cnt <= 0;
    rsp_valid <= rd_valid && rd_ready;
    rsp_data  <= mem_word(rd_addr);
    rsp_err   <= rd_err_mode;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      mismatched++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  logic [1:0] exp_cnt = 2'd0;
  logic [31:0] exp_exc = 32'd0;

  task automatic walk(input logic [31:0] base, input logic [31:0] va, input logic is_d,
                      input int mode, input int stall, input logic poison);
    logic [31:0] pva, ppa, pte;
    int n_xl, n_rd, n_wr;
    logic [31:0] got_xl, got_rd, got_pte, got_va;
    logic [1:0] got_way, got_ring;
    logic got_d;
    logic done;
    pva = (base | (va >> 10)) & 32'hFFFF_FFFC;
    ppa = pva ^ XL_KEY;
    pte = mem_word(ppa);
    n_xl = 0; n_rd = 0; n_wr = 0; done = 1'b0;
    got_xl = '0; got_rd = '0; got_pte = '0; got_va = '0; got_way = '0; got_ring = '0; got_d = 1'b0;
    @(negedge clk);
    xl_fail_mode = (mode == 1);
    rd_err_mode  = (mode == 2);
    stall_len    = stall;
    pt_base      = base;
    chk("R10 ready before miss", {31'd0, miss_ready}, 32'd1);
    miss_valid   = 1'b1;
    miss_vaddr   = va;
    miss_is_data = is_d;
    @(posedge clk);
    #1;
    if (poison) miss_vaddr = 32'hDEAD_BEEF;
    else miss_valid = 1'b0;
    for (int i = 0; i < 40 && !done; i++) begin
      @(negedge clk);
      if (xl_valid) begin n_xl++; got_xl = xl_vaddr;
        chk("R10 busy not ready", {31'd0, miss_ready}, 32'd0); end
      if (rd_valid && rd_ready) begin n_rd++; got_rd = rd_addr; end
      if (wr_en) begin n_wr++; got_pte = wr_pte; got_va = wr_vaddr;
        got_way = wr_way; got_ring = wr_ring; got_d = wr_is_data; end
      if (resp_valid) begin
        done = 1'b1;
        chk("R3/R5 fail flag", {31'd0, resp_fail}, {31'd0, mode != 0});
        chk("R9 cause", {26'd0, resp_cause},
            (mode == 0) ? 32'd0 : (is_d ? 32'd24 : 32'd16));
      end
    end
    miss_valid = 1'b0;
    chk("R10 one walk only", n_xl, 1);
    chk("R2 pte vaddr", got_xl, pva);
    chk("R3/R4 reads issued", n_rd, (mode == 1) ? 0 : 1);
    if (mode != 1) chk("R4 read addr", got_rd, ppa);
    chk("R3/R5/R6 writes", n_wr, (mode == 0) ? 1 : 0);
    if (mode == 0) begin
      exp_cnt = exp_cnt + 2'd1;
      exp_exc = va;
      chk("R6 pte", got_pte, pte);
      chk("R6 vaddr", got_va, va);
      chk("R6 ring", {30'd0, got_ring}, {30'd0, pte[5:4]});
      chk("R6 kind", {31'd0, got_d}, {31'd0, is_d});
      chk("R7 way", {30'd0, got_way}, {30'd0, exp_cnt});
    end
    @(negedge clk);
    chk("R8 excvaddr", excvaddr, exp_exc);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 ready", {31'd0, miss_ready}, 32'd1);
    chk("R1 resp", {31'd0, resp_valid}, 32'd0);
    chk("R1 wr", {31'd0, wr_en}, 32'd0);
    chk("R1 xl/rd", {30'd0, xl_valid, rd_valid}, 32'd0);
    chk("R1 excvaddr", excvaddr, 32'd0);
    for (int b = 0; b < 3; b++) begin
      for (int v = 0; v < 8; v++) begin
        for (int m = 0; m < 3; m++) begin
          walk(32'hC000_0000 + (b << 22) + (b * 32'h1234),
               (v * 32'h2468_ACE5) ^ (b << 29) ^ 32'h0000_0C03,
               v[0], m, (v + m) % 3, (v % 4) == 3);
        end
      end
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule